// File: doc/BRIEF.md
# Carrier-Gap Downlink Encoder for Low-Frequency Transponders

This block sends commands to a 125 kHz transponder by switching the reader carrier on and off. The transponder tells bits apart by how long the carrier stays on between short, fixed field-off gaps. A short on-interval is a 0 and a long on-interval is a 1. A host places a command code, an optional password with its enable flag, a data word and a block address on the inputs, then pulses a start request. While the block works, the host leaves it alone.

The block holds the carrier on for a power-up settling period so the transponder can configure itself. It then drops the carrier for a start gap and sends the frame bits, each followed by a write gap. Finally it turns the carrier back on and holds it for a listening settle interval. It pulses `done_o` when response capture may begin. All intervals are counted in field clocks. A prescaler derives the field clock from the system clock, and every interval counter advances only on that tick. After a command the carrier stays on until the next command or a field-off request.

Command codes on `cmd_i` are 0 for a block write, 1 for a block read, 2 for a trace-page read, and 3, which is reserved.

Top module: `lf_gap_encoder`

## Requirements
- R1: After synchronous reset, `carrier_on_o`, `busy_o` and `done_o` are all low.
- R2: A start request is accepted in idle. The carrier then stays on for exactly POWERUP_FC field clocks (POWERUP_FC×TICK_DIV system clocks), and `busy_o` stays high for the whole command.
- R3: Right after the power-up interval, the carrier is off for START_FC (default 30) field clocks.
- R4: A 0 bit holds the carrier on for ZERO_FC (default 24) field clocks, and a 1 bit holds it on for ONE_FC (default 54) field clocks. Every bit is followed by GAP_FC (default 20) field clocks of carrier off.
- R5: A block write (code 0) sends these fields, each MSB first:
  - 1, 0;
  - the 32-bit password, only when `pwd_en_i` is high;
  - 0;
  - the 32 data bits;
  - the 3 address bits.
- R6: A block read (code 1) sends these fields, each MSB first:
  - 1, 0;
  - the password, only when enabled;
  - 0;
  - the 3 address bits.

  No data bits are sent.
- R7: A trace-page read (code 2) sends only the two bits 1, 1.
- R8: After the last write gap, the carrier is on for SETTLE_FC (default 150) field clocks. Then `done_o` is high for exactly one cycle, and `busy_o` is low from that cycle on.
- R9: A start request while `busy_o` is high is ignored, and the frame being sent is unchanged.
- R10: After a command the carrier stays on while idle until `field_off_i` is pulsed, which turns it off on the next cycle. `field_off_i` has no effect while busy.
- R11: A start request with reserved code 3 is ignored: `busy_o` stays low and the carrier is unchanged.
- R12: Reset asserted in the middle of a command turns the carrier off and clears `busy_o` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| cmd_i | input | 2 | Command code: 0 write, 1 block read, 2 trace read, 3 reserved |
| pwd_en_i | input | 1 | Insert the password into write and block-read frames |
| pwd_i | input | 32 | Password, sent MSB first |
| data_i | input | 32 | Write data, sent MSB first |
| addr_i | input | 3 | Block address, sent MSB first |
| field_off_i | input | 1 | Turns the carrier off while idle |
| carrier_on_o | output | 1 | Carrier enable (registered) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when response capture may begin |

## Verification
The hardest situation to reach from the ports is a second start request or a field-off request arriving in the middle of a frame. On a correct design it leaves no trace at all. The bench reaches it by injecting both requests, with a different command code, while a long write frame is being sent. It then decodes every carrier interval of that command back into bits, so any restart, truncation or dropped gap shows up as a frame or timing mismatch. Reset in the middle of a command is reached the same way, followed by a fresh command to show that the sequencer recovered.

// File: rtl/lfdl_pkg.sv
package lfdl_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_READ  = 2'd1,
    CMD_TRACE = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_START,
    ST_MARK,
    ST_SPACE,
    ST_SETTLE
  } seq_state_e;
endpackage

// File: rtl/lfdl_tick.sv
module lfdl_tick #(
  parameter int DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // R2: field-clock ticks are single-cycle when the divider exceeds one
      p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/lfdl_frame.sv
module lfdl_frame
  import lfdl_pkg::*;
#(
  parameter int PWD_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [1:0]        cmd_i,
  input  logic              pwd_en_i,
  input  logic [PWD_W-1:0]  pwd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              empty_o
);
  localparam int FRAME_W = 3 + PWD_W + DATA_W + ADDR_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam logic [LEN_W-1:0] L_WR_PW = LEN_W'(FRAME_W);
  localparam logic [LEN_W-1:0] L_WR    = LEN_W'(FRAME_W - PWD_W);
  localparam logic [LEN_W-1:0] L_RD_PW = LEN_W'(FRAME_W - DATA_W);
  localparam logic [LEN_W-1:0] L_RD    = LEN_W'(3 + ADDR_W);
  localparam logic [LEN_W-1:0] L_TR    = LEN_W'(2);

  logic [FRAME_W-1:0] frame_n, frame_q;
  logic [LEN_W-1:0]   len_n, left_q;

  always_comb begin
    frame_n = {2'b11, {(FRAME_W-2){1'b0}}};
    len_n   = L_TR;
    unique case (cmd_i)
      CMD_WRITE: begin
        if (pwd_en_i) begin
          frame_n = {2'b10, pwd_i, 1'b0, data_i, addr_i};
          len_n   = L_WR_PW;
        end else begin
          frame_n = {2'b10, 1'b0, data_i, addr_i, {PWD_W{1'b0}}};
          len_n   = L_WR;
        end
      end
      CMD_READ: begin
        if (pwd_en_i) begin
          frame_n = {2'b10, pwd_i, 1'b0, addr_i, {DATA_W{1'b0}}};
          len_n   = L_RD_PW;
        end else begin
          frame_n = {2'b10, 1'b0, addr_i, {(PWD_W+DATA_W){1'b0}}};
          len_n   = L_RD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      frame_q <= frame_n;
      left_q  <= len_n;
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      left_q  <= left_q - 1'b1;
    end
  end

  assign bit_o   = frame_q[FRAME_W-1];
  assign empty_o = (left_q == '0);

  // R4: a bit is only retired while the frame still holds one
  p_shift_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    shift_i |-> !empty_o);
endmodule

// File: rtl/lfdl_seq.sv
module lfdl_seq
  import lfdl_pkg::*;
#(
  parameter int POWERUP_FC = 18750,
  parameter int START_FC   = 30,
  parameter int GAP_FC     = 20,
  parameter int ZERO_FC    = 24,
  parameter int ONE_FC     = 54,
  parameter int SETTLE_FC  = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] cmd_i,
  input  logic       field_off_i,
  input  logic       tick_i,
  input  logic       bit_i,
  input  logic       empty_i,
  output logic       load_o,
  output logic       shift_o,
  output logic       carrier_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int M1 = (POWERUP_FC > SETTLE_FC) ? POWERUP_FC : SETTLE_FC;
  localparam int M2 = (ONE_FC > ZERO_FC) ? ONE_FC : ZERO_FC;
  localparam int M3 = (START_FC > GAP_FC) ? START_FC : GAP_FC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M4 > M3) ? M4 : M3;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             car_n, done_n;
  logic             iv_end;

  assign load_o  = (state_q == ST_IDLE) && start_i && (cmd_i != CMD_RSVD);
  assign iv_end  = tick_i && (cnt_q == CNT_W'(1));
  assign shift_o = (state_q == ST_MARK) && iv_end;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    car_n   = carrier_o;
    done_n  = 1'b0;
    if (state_q != ST_IDLE && tick_i && !iv_end) cnt_n = cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (load_o) begin
          state_n = ST_POWER;
          cnt_n   = CNT_W'(POWERUP_FC);
          car_n   = 1'b1;
        end else if (field_off_i) begin
          car_n   = 1'b0;
        end
      end
      ST_POWER: if (iv_end) begin
        state_n = ST_START;
        cnt_n   = CNT_W'(START_FC);
        car_n   = 1'b0;
      end
      ST_START: if (iv_end) begin
        state_n = ST_MARK;
        cnt_n   = bit_i ? CNT_W'(ONE_FC) : CNT_W'(ZERO_FC);
        car_n   = 1'b1;
      end
      ST_MARK: if (iv_end) begin
        state_n = ST_SPACE;
        cnt_n   = CNT_W'(GAP_FC);
        car_n   = 1'b0;
      end
      ST_SPACE: if (iv_end) begin
        car_n = 1'b1;
        if (empty_i) begin
          state_n = ST_SETTLE;
          cnt_n   = CNT_W'(SETTLE_FC);
        end else begin
          state_n = ST_MARK;
          cnt_n   = bit_i ? CNT_W'(ONE_FC) : CNT_W'(ZERO_FC);
        end
      end
      ST_SETTLE: if (iv_end) begin
        state_n = ST_IDLE;
        cnt_n   = '0;
        done_n  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      carrier_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      carrier_o <= car_n;
      busy_o    <= (state_n != ST_IDLE);
      done_o    <= done_n;
    end
  end

  // R8: completion is flagged for a single cycle only
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R12: reset leaves the carrier off and the sequencer not busy
  p_reset_off_r12: assert property (@(posedge clk)
    rst |=> (!carrier_o && !busy_o));

  // R10: an idle carrier stays on without a field-off or start request
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && carrier_o && !field_off_i && !start_i) |=> carrier_o);

  // R4: interval counters move only on a field-clock tick
  p_cnt_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lf_gap_encoder.sv
module lf_gap_encoder #(
  parameter int TICK_DIV   = 2000,
  parameter int POWERUP_FC = 18750,
  parameter int START_FC   = 30,
  parameter int GAP_FC     = 20,
  parameter int ZERO_FC    = 24,
  parameter int ONE_FC     = 54,
  parameter int SETTLE_FC  = 150,
  parameter int PWD_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic              pwd_en_i,
  input  logic [PWD_W-1:0]  pwd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              field_off_i,
  output logic              carrier_on_o,
  output logic              busy_o,
  output logic              done_o
);
  logic load, shift, tick, cur_bit, empty;

  lfdl_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (load),
    .tick_o (tick)
  );

  lfdl_frame #(.PWD_W(PWD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .cmd_i    (cmd_i),
    .pwd_en_i (pwd_en_i),
    .pwd_i    (pwd_i),
    .data_i   (data_i),
    .addr_i   (addr_i),
    .shift_i  (shift),
    .bit_o    (cur_bit),
    .empty_o  (empty)
  );

  lfdl_seq #(
    .POWERUP_FC (POWERUP_FC),
    .START_FC   (START_FC),
    .GAP_FC     (GAP_FC),
    .ZERO_FC    (ZERO_FC),
    .ONE_FC     (ONE_FC),
    .SETTLE_FC  (SETTLE_FC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cmd_i       (cmd_i),
    .field_off_i (field_off_i),
    .tick_i      (tick),
    .bit_i       (cur_bit),
    .empty_i     (empty),
    .load_o      (load),
    .shift_o     (shift),
    .carrier_o   (carrier_on_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/lf_gap_encoder_tb.sv
module lf_gap_encoder_tb;
  localparam int D  = 4;
  localparam int PU = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] cmd_i = 2'd0;
  logic pwd_en_i = 1'b0;
  logic [31:0] pwd_i = '0;
  logic [31:0] data_i = '0;
  logic [2:0] addr_i = '0;
  logic field_off_i = 1'b0;
  logic carrier_on_o, busy_o, done_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  lf_gap_encoder #(.TICK_DIV(D), .POWERUP_FC(PU)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i),
    .pwd_en_i(pwd_en_i), .pwd_i(pwd_i), .data_i(data_i), .addr_i(addr_i),
    .field_off_i(field_off_i), .carrier_on_o(carrier_on_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: act=%0d exp<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!carrier_on_o && !busy_o && !done_o, "R1 reset state",
          {carrier_on_o, busy_o, done_o}, 0);
  endtask

  // Runs one command, records every carrier interval and decodes the frame.
  task automatic run_cmd(input logic [1:0] cmd, input bit pen, input logic [31:0] pw,
                         input logic [31:0] dt, input logic [2:0] ad, input bit poke,
                         input string frame_req);
    int runs[256];
    bit lv[256];
    int n = 0, run = 0, k = 0, nb = 0, badm = 0, badg = 0, en = 0;
    bit prev, tmo = 0, b;
    logic [69:0] exp, dec;
    dec = '0;
    case (cmd)
      2'd0: begin
        if (pen) begin exp = {2'b10, pw, 1'b0, dt, ad}; en = 70; end
        else begin exp = 70'({2'b10, 1'b0, dt, ad}); en = 38; end
      end
      2'd1: begin
        if (pen) begin exp = 70'({2'b10, pw, 1'b0, ad}); en = 38; end
        else begin exp = 70'({2'b10, 1'b0, ad}); en = 6; end
      end
      default: begin exp = 70'(2'b11); en = 2; end
    endcase
    @(negedge clk);
    cmd_i = cmd; pwd_en_i = pen; pwd_i = pw; data_i = dt; addr_i = ad; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    prev = carrier_on_o; run = 1;
    forever begin
      @(negedge clk);
      k++;
      start_i = 1'b0; field_off_i = 1'b0; cmd_i = cmd;
      if (poke && k == 400) begin
        check(busy_o, "R9 busy during frame", busy_o, 1);
        start_i = 1'b1; cmd_i = 2'd2; field_off_i = 1'b1;
      end
      if (done_o) begin
        if (n < 256) begin runs[n] = run; lv[n] = prev; end
        n++;
        break;
      end
      if (k > 60000) begin tmo = 1; break; end
      if (carrier_on_o == prev) run++;
      else begin
        if (n < 256) begin runs[n] = run; lv[n] = prev; end
        n++; prev = carrier_on_o; run = 1;
      end
    end
    start_i = 1'b0; field_off_i = 1'b0;
    check(!tmo, "R8 done reached", tmo, 0);
    if (tmo || n < 3 || n > 255 || (n % 2) == 0) begin
      check(0, "R4 interval count", n, 2 * en + 3);
      return;
    end
    check(lv[0] && runs[0] == PU * D, "R2 power-up length", runs[0], PU * D);
    check(!lv[1] && runs[1] == 30 * D, "R3 start gap length", runs[1], 30 * D);
    for (int i = 2; i < n - 1; i += 2) begin
      b = 1'b0;
      if (lv[i] && runs[i] == 24 * D) b = 1'b0;
      else if (lv[i] && runs[i] == 54 * D) b = 1'b1;
      else badm++;
      if (lv[i+1] || runs[i+1] != 20 * D) badg++;
      dec = {dec[68:0], b};
      nb++;
    end
    check(badm == 0, "R4 mark lengths", badm, 0);
    check(badg == 0, "R4 gap lengths", badg, 0);
    check(nb == en, {frame_req, " bit count"}, nb, en);
    check(dec == exp, {frame_req, " frame bits"}, dec, exp);
    if (poke) check(nb == en && dec == exp, "R9 frame unchanged by start while busy", dec, exp);
    check(lv[n-1] && runs[n-1] == 150 * D, "R8 settle length", runs[n-1], 150 * D);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 done one cycle, busy low", {done_o, busy_o}, 0);
    check(carrier_on_o, "R10 carrier held after command", carrier_on_o, 1);
  endtask

  task automatic t_field_off();
    repeat (20) @(negedge clk);
    check(carrier_on_o, "R10 carrier still on while idle", carrier_on_o, 1);
    field_off_i = 1'b1;
    @(negedge clk);
    field_off_i = 1'b0;
    check(!carrier_on_o, "R10 field-off turns carrier off", carrier_on_o, 0);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    cmd_i = 2'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!busy_o && !carrier_on_o, "R11 reserved code ignored", {busy_o, carrier_on_o}, 0);
    repeat (10 * D) @(negedge clk);
    check(!busy_o && !carrier_on_o, "R11 reserved code stays idle", {busy_o, carrier_on_o}, 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    cmd_i = 2'd0; pwd_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    check(busy_o, "R12 busy before reset", busy_o, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!carrier_on_o && !busy_o, "R12 reset mid-command", {carrier_on_o, busy_o}, 0);
  endtask

  initial begin
    t_reset();
    run_cmd(2'd0, 1'b1, 32'hA5C3_0F96, 32'h1234_5678, 3'd5, 1'b0, "R5 write+pwd");
    run_cmd(2'd0, 1'b0, 32'hFFFF_FFFF, 32'h8000_0001, 3'd2, 1'b0, "R5 write");
    run_cmd(2'd1, 1'b1, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 3'd7, 1'b0, "R6 read+pwd");
    run_cmd(2'd1, 1'b0, 32'h0, 32'h0, 3'd1, 1'b0, "R6 read");
    run_cmd(2'd2, 1'b1, 32'h1111_1111, 32'h2222_2222, 3'd3, 1'b0, "R7 trace");
    t_field_off();
    t_reserved();
    run_cmd(2'd0, 1'b0, 32'h0, 32'hC001_D00D, 3'd6, 1'b1, "R5 write with poke");
    t_reset_mid();
    run_cmd(2'd2, 1'b0, 32'h0, 32'h0, 3'd0, 1'b0, "R7 trace after reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule